// File: doc/BRIEF.md
# Interrupt Instruction-Jam Fetch Controller

This block steers the fetch stage of a small 8-bit processor that has no interrupt vector hardware. At every instruction boundary it either reads the next opcode from memory and lets the program counter advance, or, when an interrupt request is pending, runs an acknowledge fetch. In an acknowledge fetch the opcode is taken from the interrupting device's data bus, the memory read is suppressed and the program counter does not advance. The memory opcode that was displaced is therefore fetched again once the injected instruction has run. No mask exists, so every request is served at the next boundary. No register or flag is saved on entry.

The device normally injects one of eight single-byte call opcodes (pattern `00_nnn_101`). The controller decodes this pattern on every fetch and reports the target address `n*8`. It also reports the return address the call must push. For an injected call this is the current, unadvanced PC. For a call read from memory it is PC+1. The execution datapath marks instruction completion with `instr_done` and reports an executed halt with `halt_cmd`. A halt parks the controller until a request arrives. It always leaves through an acknowledge fetch.

The FSM has three states. `ST_FETCH` lasts one cycle, in which the opcode is presented. It always moves to `ST_EXEC`. `ST_EXEC` waits for `instr_done`. With `halt_cmd` set it moves to `ST_HALT`, and without it back to `ST_FETCH`. `ST_HALT` waits for a pending request and then moves to `ST_FETCH`.

Top module: `irqjam_fetch`

## Requirements
- R1: In the first cycle after reset is released, the controller is in a memory fetch: `op_valid`=1, `mem_rd`=1, `pc_inc`=1, `irq_ack`=0.
- R2: A fetch with no pending request presents `mem_rdata` on `opcode`, with `mem_rd`=1, `pc_inc`=1 and `irq_ack`=0. This lasts exactly one cycle. No further fetch occurs until `instr_done` is seen.
- R3: A fetch with a request pending is an acknowledge fetch. `opcode` equals `dev_data`, `irq_ack`=1, `pc_inc`=0 and `mem_rd`=0, all for exactly one cycle.
- R4: A one-cycle `irq_req` pulse arriving while an instruction executes, or during a memory fetch, is held pending. It is served at the next instruction boundary. It does not alter a fetch already under way.
- R5: The acknowledge fetch clears the pending request. `irq_req` sampled in the acknowledge cycle is treated as the same request, so exactly one acknowledge results.
- R6: `instr_done` together with `halt_cmd` during execution enters the halt state. While halted, `op_valid`, `mem_rd` and `irq_ack` stay 0.
- R7: A request seen while halted leads to an acknowledge fetch. The pulse is sampled at edge k, the controller leaves halt at edge k+1, and the acknowledge fetch is presented in the cycle after that edge.
- R8: During any fetch, an opcode whose top two bits are 00 and whose low three bits are 101 raises `rst_hit`, and `rst_target` equals bits [5:3] times 8. Any other opcode gives `rst_hit`=0 and `rst_target`=0.
- R9: `ret_addr` equals `pc_in` during an acknowledge fetch. During a memory fetch it equals `pc_in`+1, wrapping modulo 2^ADDR_W.
- R10: `instr_done` while halted, and `halt_cmd` without `instr_done` during execution, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Interrupt request from the device (pulse or level) |
| instr_done | input | 1 | Current instruction has completed |
| halt_cmd | input | 1 | Completing instruction was a halt (qualified by instr_done) |
| pc_in | input | ADDR_W (14) | Current program counter |
| mem_rdata | input | DATA_W (8) | Opcode byte read from memory |
| dev_data | input | DATA_W (8) | Opcode byte driven by the interrupting device |
| mem_rd | output | 1 | Memory opcode read strobe |
| op_valid | output | 1 | `opcode` is valid this cycle |
| opcode | output | DATA_W (8) | Fetched opcode |
| pc_inc | output | 1 | Program counter may advance |
| irq_ack | output | 1 | Acknowledge fetch strobe to the device |
| rst_hit | output | 1 | Fetched opcode is a single-byte vector call |
| rst_target | output | ADDR_W (14) | Vector call target address |
| ret_addr | output | ADDR_W (14) | Return address a call must push |

## Verification
Every cycle, the assertions check several properties. They confirm that an acknowledge fetch never advances the PC or reads memory, and that it lasts one cycle. They confirm that a plain fetch does both. They check that a pending request is never dropped without an acknowledge, that a halt never fetches, that a pending request in halt is acknowledged on the next cycle, and that vector decode and return addresses follow R8 and R9. The directed scenarios show what a per-cycle property cannot. These are the latency from a pulse to its acknowledge across a long execution, and the single acknowledge for a level request held through the acknowledge edge. They also cover the return to memory fetching once the request is consumed, the address wrap, and the inputs that are ignored in halt and mid-execution.

// File: rtl/irqjam_pkg.sv
package irqjam_pkg;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_EXEC  = 2'd1,
        ST_HALT  = 2'd2
    } fetch_state_e;

    // Single-byte vector call encoding: prefix | index | tag
    localparam int          VEC_IDX_LO = 3;
    localparam int          VEC_IDX_W  = 3;
    localparam int          VEC_TAG_W  = 3;
    localparam logic [2:0]  VEC_TAG    = 3'b101;

endpackage

// File: rtl/irqjam_pending.sv
module irqjam_pending (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic ack,
    output logic pend
);

    logic pend_nx;

    // A request seen in the acknowledge cycle belongs to the request being served
    always_comb begin
        pend_nx = pend;
        if (ack) begin
            pend_nx = 1'b0;
        end else if (req) begin
            pend_nx = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else begin
            pend <= pend_nx;
        end
    end

endmodule

// File: rtl/irqjam_fsm.sv
module irqjam_fsm
    import irqjam_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pend,
    input  logic         instr_done,
    input  logic         halt_cmd,
    output fetch_state_e state,
    output logic         fetch_now,
    output logic         jam_now
);

    fetch_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FETCH: state_nx = ST_EXEC;
            ST_EXEC: begin
                if (instr_done) begin
                    state_nx = halt_cmd ? ST_HALT : ST_FETCH;
                end
            end
            ST_HALT: begin
                if (pend) begin
                    state_nx = ST_FETCH;
                end
            end
            default: state_nx = ST_FETCH;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_FETCH;
        end else begin
            state <= state_nx;
        end
    end

    // Outputs
    always_comb begin
        fetch_now = 1'b0;
        jam_now   = 1'b0;
        unique case (state)
            ST_FETCH: begin
                fetch_now = 1'b1;
                jam_now   = pend;
            end
            ST_EXEC:  ;
            ST_HALT:  ;
            default:  ;
        endcase
    end

endmodule

// File: rtl/irqjam_opsel.sv
module irqjam_opsel
    import irqjam_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 14,
    parameter int VEC_SHIFT = 3
) (
    input  logic              fetch_now,
    input  logic              jam_now,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] dev_data,
    input  logic [ADDR_W-1:0] pc_in,
    output logic              mem_rd,
    output logic              op_valid,
    output logic [DATA_W-1:0] opcode,
    output logic              pc_inc,
    output logic              irq_ack,
    output logic              rst_hit,
    output logic [ADDR_W-1:0] rst_target,
    output logic [ADDR_W-1:0] ret_addr
);

    localparam int PFX_LO = VEC_IDX_LO + VEC_IDX_W;
    localparam int PFX_W  = DATA_W - PFX_LO;

    logic [VEC_IDX_W-1:0] vec_idx;
    logic                 is_vec;

    always_comb begin
        op_valid = fetch_now;
        irq_ack  = fetch_now & jam_now;
        mem_rd   = fetch_now & ~jam_now;
        pc_inc   = fetch_now & ~jam_now;
        opcode   = '0;
        if (fetch_now) begin
            opcode = jam_now ? dev_data : mem_rdata;
        end
    end

    assign vec_idx = opcode[VEC_IDX_LO +: VEC_IDX_W];
    assign is_vec  = (opcode[PFX_LO +: PFX_W] == '0)
                   && (opcode[VEC_TAG_W-1:0] == VEC_TAG);

    always_comb begin
        rst_hit    = fetch_now & is_vec;
        rst_target = '0;
        if (rst_hit) begin
            rst_target = ADDR_W'(vec_idx) << VEC_SHIFT;
        end
        ret_addr = pc_in + {{(ADDR_W-1){1'b0}}, pc_inc};
    end

endmodule

// File: rtl/irqjam_fetch.sv
module irqjam_fetch
    import irqjam_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 14,
    parameter int VEC_SHIFT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_req,
    input  logic              instr_done,
    input  logic              halt_cmd,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] dev_data,
    output logic              mem_rd,
    output logic              op_valid,
    output logic [DATA_W-1:0] opcode,
    output logic              pc_inc,
    output logic              irq_ack,
    output logic              rst_hit,
    output logic [ADDR_W-1:0] rst_target,
    output logic [ADDR_W-1:0] ret_addr
);

    logic         pend;
    fetch_state_e state;
    logic         fetch_now;
    logic         jam_now;

    irqjam_pending u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (irq_req),
        .ack   (irq_ack),
        .pend  (pend)
    );

    irqjam_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend       (pend),
        .instr_done (instr_done),
        .halt_cmd   (halt_cmd),
        .state      (state),
        .fetch_now  (fetch_now),
        .jam_now    (jam_now)
    );

    irqjam_opsel #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .VEC_SHIFT (VEC_SHIFT)
    ) u_opsel (
        .fetch_now  (fetch_now),
        .jam_now    (jam_now),
        .mem_rdata  (mem_rdata),
        .dev_data   (dev_data),
        .pc_in      (pc_in),
        .mem_rd     (mem_rd),
        .op_valid   (op_valid),
        .opcode     (opcode),
        .pc_inc     (pc_inc),
        .irq_ack    (irq_ack),
        .rst_hit    (rst_hit),
        .rst_target (rst_target),
        .ret_addr   (ret_addr)
    );

endmodule

// File: rtl/irqjam_chk.sv
module irqjam_chk
    import irqjam_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pend,
    input fetch_state_e      state,
    input logic              mem_rd,
    input logic              op_valid,
    input logic [DATA_W-1:0] opcode,
    input logic              pc_inc,
    input logic              irq_ack,
    input logic              rst_hit,
    input logic [ADDR_W-1:0] pc_in,
    input logic [ADDR_W-1:0] ret_addr
);

    // R3
    jam_no_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> (!pc_inc && !mem_rd && op_valid));

    // R3
    ack_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq_ack);

    // R2
    plain_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !irq_ack) |-> (pc_inc && mem_rd));

    // R2
    fetch_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> !op_valid);

    // R4
    pend_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !irq_ack) |=> pend);

    // R6
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |-> (!op_valid && !mem_rd && !irq_ack));

    // R7
    halt_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_HALT) && pend) |=> irq_ack);

    // R8
    vec_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (opcode[7:6] == 2'b00) && (opcode[2:0] == 3'b101)) |-> rst_hit);

    // R9
    jam_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> (ret_addr == pc_in));

endmodule

bind irqjam_fetch irqjam_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend     (pend),
    .state    (state),
    .mem_rd   (mem_rd),
    .op_valid (op_valid),
    .opcode   (opcode),
    .pc_inc   (pc_inc),
    .irq_ack  (irq_ack),
    .rst_hit  (rst_hit),
    .pc_in    (pc_in),
    .ret_addr (ret_addr)
);

// File: tb/sim_irqjam_fetch.sv
module sim_irqjam_fetch;

    localparam int DW = 8;
    localparam int AW = 14;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          irq_req;
    logic          instr_done;
    logic          halt_cmd;
    logic [AW-1:0] pc_in;
    logic [DW-1:0] mem_rdata;
    logic [DW-1:0] dev_data;
    logic          mem_rd;
    logic          op_valid;
    logic [DW-1:0] opcode;
    logic          pc_inc;
    logic          irq_ack;
    logic          rst_hit;
    logic [AW-1:0] rst_target;
    logic [AW-1:0] ret_addr;

    int n_chk = 0;
    int n_err = 0;
    bit reported = 1'b0;

    always #4 clk = ~clk;

    irqjam_fetch u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_req    (irq_req),
        .instr_done (instr_done),
        .halt_cmd   (halt_cmd),
        .pc_in      (pc_in),
        .mem_rdata  (mem_rdata),
        .dev_data   (dev_data),
        .mem_rd     (mem_rd),
        .op_valid   (op_valid),
        .opcode     (opcode),
        .pc_inc     (pc_inc),
        .irq_ack    (irq_ack),
        .rst_hit    (rst_hit),
        .rst_target (rst_target),
        .ret_addr   (ret_addr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!reported) begin
            reported = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // Expects a memory fetch this cycle; leaves the controller in execution
    task automatic mem_fetch(input string tag, input logic [DW-1:0] op, input logic [AW-1:0] pc,
                             input logic hit, input logic [AW-1:0] tgt);
        mem_rdata = op;
        dev_data  = 8'hA5;
        pc_in     = pc;
        #1;
        check({tag, " op_valid"}, op_valid, 1);
        check({tag, " opcode"},   opcode, op);
        check({tag, " mem_rd"},   mem_rd, 1);
        check({tag, " pc_inc"},   pc_inc, 1);
        check({tag, " irq_ack"},  irq_ack, 0);
        check({tag, " R9 ret_addr"}, ret_addr, AW'(pc + 14'd1));
        check({tag, " R8 rst_hit"}, rst_hit, hit);
        check({tag, " R8 rst_target"}, rst_target, tgt);
        tick();
    endtask

    // Expects an acknowledge fetch this cycle; leaves the controller in execution
    task automatic jam_fetch(input string tag, input logic [DW-1:0] op, input logic [AW-1:0] pc,
                             input logic hit, input logic [AW-1:0] tgt);
        dev_data  = op;
        mem_rdata = 8'hEE;
        pc_in     = pc;
        #1;
        check({tag, " op_valid"}, op_valid, 1);
        check({tag, " opcode"},   opcode, op);
        check({tag, " mem_rd"},   mem_rd, 0);
        check({tag, " pc_inc"},   pc_inc, 0);
        check({tag, " irq_ack"},  irq_ack, 1);
        check({tag, " R9 ret_addr"}, ret_addr, pc);
        check({tag, " R8 rst_hit"}, rst_hit, hit);
        check({tag, " R8 rst_target"}, rst_target, tgt);
        tick();
    endtask

    task automatic finish_instr(input logic halt);
        instr_done = 1'b1;
        halt_cmd   = halt;
        tick();
        instr_done = 1'b0;
        halt_cmd   = 1'b0;
    endtask

    task automatic expect_idle(input string tag);
        #1;
        check({tag, " op_valid"}, op_valid, 0);
        check({tag, " mem_rd"},   mem_rd, 0);
        check({tag, " irq_ack"},  irq_ack, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        mem_fetch("R1 first fetch", 8'h47, 14'h0100, 0, 0);
        expect_idle("R2 waits in exec");
        tick();
        expect_idle("R2 still waiting");
        finish_instr(0);
    endtask

    task automatic t_plain();
        mem_fetch("R2 plain a", 8'hC0, 14'h0101, 0, 0);
        finish_instr(0);
        mem_fetch("R9 wrap", 8'h1C, 14'h3FFF, 0, 0);
        finish_instr(0);
        mem_fetch("R8 vec from memory", 8'h1D, 14'h0200, 1, 14'd24);
        finish_instr(0);
        mem_fetch("R8 wrong prefix", 8'h5D, 14'h0201, 0, 0);
        finish_instr(0);
    endtask

    task automatic t_irq_midexec();
        mem_fetch("R4 fetch before irq", 8'h80, 14'h0300, 0, 0);
        irq_req = 1'b1;
        tick();
        irq_req = 1'b0;
        expect_idle("R4 held during exec");
        tick();
        expect_idle("R4 held during exec 2");
        finish_instr(0);
        jam_fetch("R3 jam mid exec", 8'h3D, 14'h0301, 1, 14'd56);
        finish_instr(0);
        mem_fetch("R5 pend cleared", 8'h81, 14'h0301, 0, 0);
        finish_instr(0);
    endtask

    task automatic t_irq_level();
        mem_fetch("R5 fetch before level", 8'h90, 14'h0400, 0, 0);
        irq_req = 1'b1;
        finish_instr(0);
        jam_fetch("R5 level jam", 8'h05, 14'h0401, 1, 14'd0);
        irq_req = 1'b0;
        finish_instr(0);
        mem_fetch("R5 single ack", 8'h91, 14'h0401, 0, 0);
        finish_instr(0);
    endtask

    task automatic t_fetch_edge();
        irq_req = 1'b1;
        mem_fetch("R4 fetch in progress kept", 8'hA0, 14'h0500, 0, 0);
        irq_req = 1'b0;
        finish_instr(0);
        jam_fetch("R4 served next boundary", 8'h2D, 14'h0501, 1, 14'd40);
        finish_instr(0);
    endtask

    task automatic t_halt_cmd_alone();
        mem_fetch("R10 fetch", 8'hB0, 14'h0600, 0, 0);
        halt_cmd = 1'b1;
        tick();
        halt_cmd = 1'b0;
        expect_idle("R10 halt_cmd alone");
        finish_instr(0);
        mem_fetch("R10 not halted", 8'hB1, 14'h0601, 0, 0);
        finish_instr(0);
    endtask

    task automatic t_halt();
        mem_fetch("R6 halt instr", 8'h00, 14'h0700, 0, 0);
        finish_instr(1);
        for (int i = 0; i < 4; i++) begin
            expect_idle("R6 halted");
            tick();
        end
        instr_done = 1'b1;
        tick();
        instr_done = 1'b0;
        expect_idle("R10 done ignored in halt");
        tick();
        expect_idle("R10 still halted");
        irq_req = 1'b1;
        tick();
        irq_req = 1'b0;
        expect_idle("R7 leaving halt");
        tick();
        jam_fetch("R7 halt exit jam", 8'h0D, 14'h0701, 1, 14'd8);
        finish_instr(0);
        mem_fetch("R7 resume memory", 8'h01, 14'h0701, 0, 0);
        finish_instr(0);
    endtask

    initial begin
        #(8 * 20000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        rst_n      = 1'b0;
        irq_req    = 1'b0;
        instr_done = 1'b0;
        halt_cmd   = 1'b0;
        pc_in      = '0;
        mem_rdata  = '0;
        dev_data   = '0;
        t_reset();
        t_plain();
        t_irq_midexec();
        t_irq_level();
        t_fetch_edge();
        t_halt_cmd_alone();
        t_halt();
        summary();
        $finish;
    end

endmodule